// File: doc/BRIEF.md
# Two-Level Event Flag Register Block

This block records hardware events in two tiers. Six event categories (system, microcontroller, serial link, voltage supervision, temperature or current limit, battery undervoltage) each own an 8-bit detailed register whose bits latch and hold their raw event inputs. A global summary register holds one bit per category. A summary bit is raised only in the cycle when a new bit appears in its detailed register. Software reads the summary first and then reads only the detailed registers it points to.

Both tiers are cleared by writing 1, and the two tiers clear on their own: clearing one tier never touches the other. The summary register also carries a read-only timeout bit. Hardware sets it from a timeout event input and drops it once no category summary bit remains set. An interrupt output stays high while any summary flag is set. Access is through a simple register port: a write strobe, an address, write data, and read data that is decoded combinationally from the address.

Top module: `evt_status_hier`

## Requirements
- R1: Each detailed register (category c at address 0x10+c: 0 system, 1 microcontroller, 2 serial link, 3 voltage supervision, 4 temperature/current, 5 battery undervoltage) resets to 0x00 and latches every input bit of its category, holding it until cleared.
- R2: Writing to a detailed register clears exactly the bits written as 1; bits written as 0 keep their value.
- R3: Summary bit c is set in the cycle after any bit of detailed register c goes from 0 to 1. An event on a bit that is already set does not set the summary bit.
- R4: The summary register at 0x1A has this layout: bit c (0 to 5) is category c, bit 6 always reads 0, and bit 7 is the timeout bit.
- R5: Writing 1 to a summary bit clears only that summary bit. All detailed registers keep their contents.
- R6: Clearing a detailed register bit leaves the summary bits unchanged.
- R7: When an event sets a flag and a write-1 clears the same flag in the same cycle, the flag ends up set. This holds in both tiers.
- R8: The timeout bit is set in the cycle after the timeout event input is high. Writes to it are ignored. Hardware clears it at the first edge at which summary bits 5..0 are all zero and no new timeout event is present.
- R9: The summary register resets to 0x00. Addresses that map to no register read 0x00, and writes to them have no effect.
- R10: The interrupt output is high exactly while the timeout bit or any of summary bits 5..0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 48 | Raw event bits; category c occupies bits [8c+7:8c] |
| tmo_evt_i | input | 1 | Interrupt-timeout event |
| bus_sel_i | input | 1 | Register port select |
| bus_we_i | input | 1 | Write strobe; a write happens when select and strobe are both high |
| bus_addr_i | input | 8 | Register address |
| bus_wdata_i | input | 8 | Write data (a 1 clears that bit) |
| bus_rdata_o | output | 8 | Read data for the current address |
| irq_o | output | 1 | Interrupt request |

## Verification
Two situations are hard to reach from the ports. The first is a hardware set and a software clear landing on the same flag in the same edge. The second is the timeout bit clearing in the same edge as the last category summary bit. The bench drives both on purpose: it applies an event together with a write-1 to the same register, and it clears the last summary bit while the timeout bit is pending. It also repeats events on bits that are already set, which shows that a pending level alone never raises a summary bit. A long random phase then runs sparse events and random writes, and a behavioural model is compared against the outputs on every clock.

// File: rtl/evt_hier_pkg.sv
package evt_hier_pkg;

    parameter int CAT_N  = 6;
    parameter int DET_W  = 8;
    parameter int ADDR_W = 8;
    parameter int DATA_W = 8;

    parameter logic [ADDR_W-1:0] DET_BASE = 8'h10;
    parameter logic [ADDR_W-1:0] GLB_ADDR = 8'h1A;

    localparam int TMO_BIT    = DATA_W - 1;
    localparam int UNUSED_BIT = DATA_W - 2;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } bus_req_t;

endpackage

// File: rtl/evt_detail_reg.sv
module evt_detail_reg #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flags_o,
    output logic         rise_o
);

    typedef struct packed {
        logic [W-1:0] flags;
    } det_state_t;

    det_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.flags = (st_q.flags & ~clr_i) | evt_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign rise_o  = |(evt_i & ~st_q.flags);

    AST_DET_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_i != '0) |=> ((flags_o & $past(evt_i)) == $past(evt_i)));  // R7
    AST_DET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i == '0) |=> ((flags_o & $past(flags_o)) == $past(flags_o)));  // R2

endmodule

// File: rtl/evt_global_reg.sv
module evt_global_reg #(
    parameter int N = 6
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] clr_i,
    input  logic         tmo_evt_i,
    output logic [N-1:0] cat_o,
    output logic         tmo_o
);

    typedef struct packed {
        logic [N-1:0] cat;
        logic         tmo;
    } glb_state_t;

    glb_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cat = (st_q.cat & ~clr_i) | rise_i;
        st_d.tmo = tmo_evt_i | (st_q.tmo & (|st_d.cat));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign cat_o = st_q.cat;
    assign tmo_o = st_q.tmo;

    AST_GLB_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rise_i != '0) |=> ((cat_o & $past(rise_i)) == $past(rise_i)));  // R3
    AST_GLB_NO_LEVEL_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((cat_o & ~$past(cat_o) & ~$past(rise_i)) == '0));  // R3
    AST_TMO_SELF_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cat_o == '0) && !$past(tmo_evt_i)) |-> !tmo_o);  // R8

endmodule

// File: rtl/evt_bus_dec.sv
module evt_bus_dec
    import evt_hier_pkg::*;
#(
    parameter int N  = CAT_N,
    parameter int DW = DET_W
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  bus_req_t        req_i,
    input  logic [N*DW-1:0] det_flags_i,
    input  logic [N-1:0]    glb_cat_i,
    input  logic            glb_tmo_i,
    output logic [N*DW-1:0] det_clr_o,
    output logic [N-1:0]    glb_clr_o,
    output logic [DW-1:0]   rdata_o
);

    logic [N-1:0] det_hit;
    logic         glb_hit;

    assign glb_hit   = (req_i.addr == GLB_ADDR);
    assign glb_clr_o = (req_i.wr && glb_hit) ? req_i.data[N-1:0] : '0;

    for (genvar c = 0; c < N; c++) begin : g_hit
        localparam logic [ADDR_W-1:0] ADR_C = DET_BASE + ADDR_W'(c);
        assign det_hit[c] = (req_i.addr == ADR_C);
        assign det_clr_o[c*DW +: DW] = (req_i.wr && det_hit[c]) ? req_i.data : '0;
    end

    always_comb begin
        rdata_o = '0;
        if (glb_hit) begin
            rdata_o[N-1:0]   = glb_cat_i;
            rdata_o[DW-1]    = glb_tmo_i;
        end
        for (int c = 0; c < N; c++) begin
            if (det_hit[c]) rdata_o = det_flags_i[c*DW +: DW];
        end
    end

    AST_DEC_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({det_hit, glb_hit}));  // R9

endmodule

// File: rtl/evt_status_hier.sv
module evt_status_hier
    import evt_hier_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [CAT_N*DET_W-1:0] evt_i,
    input  logic                   tmo_evt_i,
    input  logic                   bus_sel_i,
    input  logic                   bus_we_i,
    input  logic [ADDR_W-1:0]      bus_addr_i,
    input  logic [DATA_W-1:0]      bus_wdata_i,
    output logic [DATA_W-1:0]      bus_rdata_o,
    output logic                   irq_o
);

    bus_req_t                 req;
    logic [CAT_N*DET_W-1:0]   det_flags;
    logic [CAT_N*DET_W-1:0]   det_clr;
    logic [CAT_N-1:0]         rise;
    logic [CAT_N-1:0]         glb_clr;
    logic [CAT_N-1:0]         glb_cat;
    logic                     glb_tmo;

    assign req.wr   = bus_sel_i & bus_we_i;
    assign req.addr = bus_addr_i;
    assign req.data = bus_wdata_i;

    for (genvar c = 0; c < CAT_N; c++) begin : g_cat
        evt_detail_reg #(.W(DET_W)) u_det (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .evt_i   (evt_i[c*DET_W +: DET_W]),
            .clr_i   (det_clr[c*DET_W +: DET_W]),
            .flags_o (det_flags[c*DET_W +: DET_W]),
            .rise_o  (rise[c])
        );
    end

    evt_global_reg #(.N(CAT_N)) u_glb (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_i    (rise),
        .clr_i     (glb_clr),
        .tmo_evt_i (tmo_evt_i),
        .cat_o     (glb_cat),
        .tmo_o     (glb_tmo)
    );

    evt_bus_dec #(.N(CAT_N), .DW(DET_W)) u_dec (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_i       (req),
        .det_flags_i (det_flags),
        .glb_cat_i   (glb_cat),
        .glb_tmo_i   (glb_tmo),
        .det_clr_o   (det_clr),
        .glb_clr_o   (glb_clr),
        .rdata_o     (bus_rdata_o)
    );

    assign irq_o = glb_tmo | (|glb_cat);

    AST_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_addr_i == GLB_ADDR) |-> (bus_rdata_o[UNUSED_BIT] == 1'b0));  // R4
    AST_IRQ_WITH_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((bus_addr_i == GLB_ADDR) && (bus_rdata_o != '0)) |-> irq_o);  // R10

endmodule

// File: tb/tb_evt_status_hier.sv
`timescale 1ns/1ps
module tb_evt_status_hier;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [47:0] evt = '0;
    logic        tmo = 0;
    logic        sel = 0;
    logic        we = 0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [7:0] last_rd;

    logic [7:0] mdet [6];
    logic [7:0] mglb;
    logic       mtmo;

    always #5 clk = ~clk;

    evt_status_hier dut (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .tmo_evt_i(tmo),
        .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        if (a == 8'h1A) return {mtmo, 1'b0, mglb[5:0]};
        if (a >= 8'h10 && a <= 8'h15) return mdet[a - 8'h10];
        return 8'h00;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (a == 8'h1A) return "R3";
        if (a >= 8'h10 && a <= 8'h15) return "R1";
        return "R9";
    endfunction

    function automatic void model_update(input logic [47:0] e, input logic t,
                                         input logic w, input logic [7:0] a,
                                         input logic [7:0] d);
        logic [7:0] rises = '0;
        logic [7:0] gclr;
        for (int c = 0; c < 6; c++) begin
            logic [7:0] eb = e[c*8 +: 8];
            logic [7:0] clr = (w && a == 8'h10 + 8'(c)) ? d : 8'h00;
            if ((eb & ~mdet[c]) != 0) rises[c] = 1'b1;
            mdet[c] = (mdet[c] & ~clr) | eb;
        end
        gclr = (w && a == 8'h1A) ? (d & 8'h3F) : 8'h00;
        mglb = ((mglb & ~gclr) | rises) & 8'h3F;
        mtmo = t || (mtmo && mglb != 0);
    endfunction

    task automatic drive(input logic [47:0] e, input logic t, input logic w,
                         input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        evt = e; tmo = t; sel = 1'b1; we = w; addr = a; wdata = d;
        #1;
        last_rd = rdata;
        chk(tag_of(a), rdata, model_read(a));
        chk("R10", {7'b0, irq}, {7'b0, (mglb != 0) || mtmo});
        @(posedge clk);
        model_update(e, t, w, a, d);
    endtask

    task automatic rd(input logic [7:0] a);
        drive('0, 1'b0, 1'b0, a, 8'h00);
    endtask

    function automatic logic [47:0] ev1(input int c, input int b);
        logic [47:0] v = '0;
        v[c*8 + b] = 1'b1;
        return v;
    endfunction

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 6; c++) mdet[c] = '0;
        mglb = '0; mtmo = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R9 / R1: reset values
        rd(8'h1A); chk("R9", last_rd, 8'h00);
        rd(8'h13); chk("R1", last_rd, 8'h00);
        chk("R10", {7'b0, irq}, 8'h00);

        // R1 / R3 / R4 / R10: one event on voltage supervision bit 2
        drive(ev1(3, 2), 0, 0, 8'h00, 8'h00);
        rd(8'h13); chk("R1", last_rd, 8'h04);
        rd(8'h1A); chk("R4", last_rd, 8'h08);
        chk("R10", {7'b0, irq}, 8'h01);

        // R5: summary clear leaves detail intact
        drive('0, 0, 1, 8'h1A, 8'h08);
        rd(8'h1A); chk("R5", last_rd, 8'h00);
        rd(8'h13); chk("R5", last_rd, 8'h04);
        chk("R10", {7'b0, irq}, 8'h00);

        // R3: event on a pending bit does not re-raise summary
        drive(ev1(3, 2), 0, 0, 8'h00, 8'h00);
        rd(8'h1A); chk("R3", last_rd, 8'h00);

        // R2: write 0 keeps, write 1 clears
        drive('0, 0, 1, 8'h13, 8'h00);
        rd(8'h13); chk("R2", last_rd, 8'h04);
        drive('0, 0, 1, 8'h13, 8'h04);
        rd(8'h13); chk("R2", last_rd, 8'h00);

        // R6: detail clear leaves summary
        drive(ev1(3, 0), 0, 0, 8'h00, 8'h00);
        drive('0, 0, 1, 8'h13, 8'h01);
        rd(8'h13); chk("R6", last_rd, 8'h00);
        rd(8'h1A); chk("R6", last_rd, 8'h08);

        // R7: set beats clear in both tiers
        drive(ev1(3, 1), 0, 1, 8'h13, 8'h02);
        rd(8'h13); chk("R7", last_rd, 8'h02);
        drive(ev1(3, 3), 0, 1, 8'h1A, 8'h08);
        rd(8'h1A); chk("R7", last_rd, 8'h08);
        drive('0, 0, 1, 8'h1A, 8'h3F);
        drive('0, 0, 1, 8'h13, 8'hFF);

        // R4: bit positions per category, unused bit reads 0
        for (int c = 0; c < 6; c++) begin
            drive(ev1(c, 7), 0, 0, 8'h00, 8'h00);
            rd(8'h1A); chk("R4", last_rd, 8'(1 << c));
            drive('0, 0, 1, 8'h1A, 8'hFF);
            drive('0, 0, 1, 8'h10 + 8'(c), 8'hFF);
        end
        rd(8'h1A); chk("R4", last_rd, 8'h00);

        // R8: timeout sets, ignores writes, self clears
        drive('0, 1, 0, 8'h00, 8'h00);
        rd(8'h1A); chk("R8", last_rd, 8'h80);
        chk("R10", {7'b0, irq}, 8'h01);
        rd(8'h1A); chk("R8", last_rd, 8'h00);
        drive(ev1(0, 0), 1, 0, 8'h00, 8'h00);
        rd(8'h1A); chk("R8", last_rd, 8'h81);
        drive('0, 0, 1, 8'h1A, 8'h80);
        rd(8'h1A); chk("R8", last_rd, 8'h81);
        drive('0, 0, 1, 8'h1A, 8'h01);
        rd(8'h1A); chk("R8", last_rd, 8'h00);
        drive('0, 0, 1, 8'h10, 8'hFF);

        // R9: unmapped reads and writes
        drive(ev1(1, 4), 0, 1, 8'h16, 8'hFF);
        rd(8'h16); chk("R9", last_rd, 8'h00);
        rd(8'hFF); chk("R9", last_rd, 8'h00);
        rd(8'h11); chk("R9", last_rd, 8'h10);

        // random phase, model compared every clock
        for (int i = 0; i < 3000; i++) begin
            logic [47:0] e = '0;
            logic [7:0]  a;
            logic        w;
            for (int c = 0; c < 6; c++)
                if ($urandom % 10 == 0) e[c*8 + ($urandom % 8)] = 1'b1;
            case ($urandom % 4)
                0: a = 8'h1A;
                1: a = 8'h10 + 8'($urandom % 6);
                2: a = 8'($urandom);
                default: a = 8'h10 + 8'($urandom % 11);
            endcase
            w = ($urandom % 3 == 0);
            drive(e, ($urandom % 64 == 0), w, a, 8'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule